// File: doc/BRIEF.md
# Raster-op block transfer engine

This block moves a rectangle of bytes inside video memory. It reads a source region and a destination region, combines each pair of bytes with a selectable raster operation, and writes the result back to the destination. The rectangle is described by two base addresses, two row pitches, a width and a height. Software loads these values through a small write-only register port and then pulses a start input. A busy output stays high while the transfer runs.

In one mode the source byte is taken from a single monochrome pattern byte instead of from the source region. One bit of that pattern byte is selected per destination byte and expanded to 0x00 or 0xFF. Every memory address is reduced modulo the configured video memory size, so a rectangle that runs past the top of memory wraps to the bottom. The engine reaches memory through one synchronous single-port byte interface. A read returns its data on the cycle after it is issued.

Top module: `blit_engine`

## Requirements
- R1: The raster-op code selects the written byte. 0x00 writes 0x00, 0x0B writes the inverse of the destination byte, 0x0D writes the source byte, 0x0E writes 0xFF and 0x59 writes destination XOR source.
- R2: With any other raster-op code no memory write is issued and the destination stays unchanged. `rop_err` goes high on the cycle after such a transfer is accepted and holds until a later transfer is accepted with a supported code.
- R3: When mode bit 7 and mode bit 6 are both set, each source read goes to the source base address. Bit k of the byte returned is selected, where k is the absolute difference between the running source address and the source base, modulo 8. A 1 gives source 0xFF and a 0 gives 0x00.
- R4: With mode bit 6 set and bit 7 clear, the source is read from the running source address, as in normal operation.
- R5: Every address driven on `mem_addr` is the 32-bit running address modulo VRAM_BYTES.
- R6: Each row covers width+1 bytes at increasing addresses and there are height+1 rows. After each row, the source and destination row starts advance by their own pitches.
- R7: Each byte uses three consecutive cycles: a source read, a destination read, and the write. Read data arrives one cycle after the read is issued.
- R8: `busy` rises on the cycle after an accepted start. It stays high for exactly 3 cycles per byte and falls on the cycle after the last write cycle.
- R9: A start pulse while `busy` is high is ignored. The transfer in progress continues unchanged.
- R10: After reset, `busy`, `rop_err` and `mem_en` are low, and the base addresses and running addresses are zero.
- R11: A register write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`: 0 source base (32 bits), 1 destination base (32 bits), 2 source pitch, 3 destination pitch, 4 width, 5 height (each bits 15:0), 6 mode (bit 6 pattern enable, bit 7 colour expand), 7 raster-op code (bits 7:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Start strobe |
| busy | output | 1 | Transfer in progress |
| rop_err | output | 1 | Last accepted raster-op code was unsupported |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (read when low) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read |

## Verification
Several rectangles are used. A single byte at the reset-time zero bases confirms the cleared state. Multi-row rectangles with pitches unequal to each other and to the width separate row stepping from column stepping. Each supported raster-op code runs over non-trivial data, so a swapped or merged code shows up as a wrong written byte. An unsupported code is also run, and must produce no writes. A colour-expand run with pitch 16 and width 12 confirms that the selected bit index restarts per row and wraps modulo 8, while a pattern-only run must behave like a plain copy. Bases set above the memory size, and a rectangle that crosses the top of memory, exercise the address wrap. A start pulse inside a running transfer must not lengthen it or repeat any access.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RSRC  = 2'd1,
    ST_RDST  = 2'd2,
    ST_WRITE = 2'd3
  } blit_state_e;

  localparam logic [7:0] OP_CLEAR  = 8'h00;
  localparam logic [7:0] OP_INVDST = 8'h0B;
  localparam logic [7:0] OP_COPY   = 8'h0D;
  localparam logic [7:0] OP_SET    = 8'h0E;
  localparam logic [7:0] OP_XOR    = 8'h59;

  function automatic logic op_supported(input logic [7:0] code);
    return (code == OP_CLEAR) || (code == OP_INVDST) || (code == OP_COPY) ||
           (code == OP_SET)   || (code == OP_XOR);
  endfunction

  function automatic logic [7:0] op_result(input logic [7:0] code,
                                           input logic [7:0] s,
                                           input logic [7:0] d);
    logic [7:0] r;
    case (code)
      OP_CLEAR:  r = 8'h00;
      OP_INVDST: r = ~d;
      OP_COPY:   r = s;
      OP_SET:    r = 8'hFF;
      OP_XOR:    r = d ^ s;
      default:   r = d;
    endcase
    return r;
  endfunction

  // bit index of the pattern byte: |cur - base| mod 8
  function automatic logic [2:0] pat_bit_index(input logic [31:0] cur,
                                               input logic [31:0] base);
    logic [31:0] diff;
    diff = (cur >= base) ? (cur - base) : (base - cur);
    return diff[2:0];
  endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] src_base,
  output logic [31:0] dst_base,
  output logic [15:0] src_pitch,
  output logic [15:0] dst_pitch,
  output logic [15:0] width_m1,
  output logic [15:0] height_m1,
  output logic        pat_en,
  output logic        exp_en,
  output logic [7:0]  rop_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base  <= '0;
      dst_base  <= '0;
      src_pitch <= '0;
      dst_pitch <= '0;
      width_m1  <= '0;
      height_m1 <= '0;
      pat_en    <= 1'b0;
      exp_en    <= 1'b0;
      rop_code  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: src_base  <= cfg_wdata;
        3'd1: dst_base  <= cfg_wdata;
        3'd2: src_pitch <= cfg_wdata[15:0];
        3'd3: dst_pitch <= cfg_wdata[15:0];
        3'd4: width_m1  <= cfg_wdata[15:0];
        3'd5: height_m1 <= cfg_wdata[15:0];
        3'd6: begin
          pat_en <= cfg_wdata[6];
          exp_en <= cfg_wdata[7];
        end
        default: rop_code <= cfg_wdata[7:0];
      endcase
    end
  end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] src_base,
  input  logic [31:0] dst_base,
  input  logic [15:0] src_pitch,
  input  logic [15:0] dst_pitch,
  input  logic [15:0] width_m1,
  input  logic [15:0] height_m1,
  input  logic        rop_ok,
  output blit_state_e state,
  output logic        busy,
  output logic        rop_err,
  output logic [31:0] cur_src,
  output logic [31:0] cur_dst
);

  logic [31:0] row_src, row_dst;
  logic [15:0] col_cnt, row_cnt;
  logic        accept, last_col, last_byte;

  assign accept    = start && (state == ST_IDLE);
  assign last_col  = (col_cnt == width_m1);
  assign last_byte = last_col && (row_cnt == height_m1);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rop_err <= 1'b0;
      row_src <= '0;
      row_dst <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      col_cnt <= '0;
      row_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_RSRC;
          rop_err <= !rop_ok;
          row_src <= src_base;
          row_dst <= dst_base;
          cur_src <= src_base;
          cur_dst <= dst_base;
          col_cnt <= '0;
          row_cnt <= '0;
        end
        ST_RSRC: state <= ST_RDST;
        ST_RDST: state <= ST_WRITE;
        default: begin
          if (last_byte) begin
            state <= ST_IDLE;
          end else if (last_col) begin
            state   <= ST_RSRC;
            col_cnt <= '0;
            row_cnt <= row_cnt + 16'd1;
            row_src <= row_src + 32'(src_pitch);
            row_dst <= row_dst + 32'(dst_pitch);
            cur_src <= row_src + 32'(src_pitch);
            cur_dst <= row_dst + 32'(dst_pitch);
          end else begin
            state   <= ST_RSRC;
            col_cnt <= col_cnt + 16'd1;
            cur_src <= cur_src + 32'd1;
            cur_dst <= cur_dst + 32'd1;
          end
        end
      endcase
    end
  end

  // R9: a start pulse during a transfer does not reload the running address
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != ST_WRITE) |=> $stable(cur_dst));

  // R8: busy only ends right after a write-phase cycle
  a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state) == ST_WRITE));

  // R7: the three phases follow each other
  a_r7_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RSRC) |=> (state == ST_RDST));

  // R2: an accepted unsupported code raises the flag
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rop_ok) |=> rop_err);

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int VRAM_BYTES = 3000,
  parameter int ADDR_W     = $clog2(VRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  blit_state_e       state,
  input  logic [31:0]       src_base,
  input  logic [31:0]       cur_src,
  input  logic [31:0]       cur_dst,
  input  logic              pat_en,
  input  logic              exp_en,
  input  logic [7:0]        rop_code,
  input  logic [7:0]        mem_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam logic [31:0] SIZE32 = 32'(VRAM_BYTES);

  function automatic logic [ADDR_W-1:0] wrap(input logic [31:0] a);
    return ADDR_W'(a % SIZE32);
  endfunction

  logic       expand_on, rop_ok, write_ph;
  logic [7:0] src_q, src_next;
  logic [2:0] bit_sel;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  assign expand_on = pat_en && exp_en;
  assign rop_ok    = op_supported(rop_code);
  assign write_ph  = (state == ST_WRITE);
  assign bit_sel   = pat_bit_index(cur_src, src_base);
  assign src_addr  = expand_on ? wrap(src_base) : wrap(cur_src);
  assign dst_addr  = wrap(cur_dst);
  assign src_next  = expand_on ? {8{mem_rdata[bit_sel]}} : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n)                  src_q <= '0;
    else if (state == ST_RDST)   src_q <= src_next;
  end

  always_comb begin
    mem_en    = (state == ST_RSRC) || (state == ST_RDST) || (write_ph && rop_ok);
    mem_we    = write_ph && rop_ok;
    mem_addr  = (state == ST_RSRC) ? src_addr : dst_addr;
    mem_wdata = op_result(rop_code, src_q, mem_rdata);
  end

  // R5: every access lands inside memory
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (32'(mem_addr) < SIZE32));

  // R3: expanded source is all ones or all zeros
  a_r3_expand_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (write_ph && expand_on) |-> (src_q == 8'h00 || src_q == 8'hFF));

  // R2: unsupported code never writes
  a_r2_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !rop_ok) |-> !mem_we);

  // R7: writes never come back to back
  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int VRAM_BYTES = 3000,
  parameter int ADDR_W     = $clog2(VRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  output logic              busy,
  output logic              rop_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  logic [31:0] src_base, dst_base, cur_src, cur_dst;
  logic [15:0] src_pitch, dst_pitch, width_m1, height_m1;
  logic        pat_en, exp_en;
  logic [7:0]  rop_code;
  blit_state_e state;

  blit_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch), .width_m1(width_m1),
    .height_m1(height_m1), .pat_en(pat_en), .exp_en(exp_en),
    .rop_code(rop_code)
  );

  blit_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
    .dst_base(dst_base), .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .width_m1(width_m1), .height_m1(height_m1),
    .rop_ok(op_supported(rop_code)), .state(state), .busy(busy),
    .rop_err(rop_err), .cur_src(cur_src), .cur_dst(cur_dst)
  );

  blit_datapath #(.VRAM_BYTES(VRAM_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .src_base(src_base),
    .cur_src(cur_src), .cur_dst(cur_dst), .pat_en(pat_en), .exp_en(exp_en),
    .rop_code(rop_code), .mem_rdata(mem_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: tb/sim_blit_engine.sv
module sim_blit_engine;

  localparam int V  = 3000;
  localparam int AW = $clog2(V);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          start = 1'b0;
  logic          busy, rop_err, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;

  logic [7:0] vram   [V];
  logic [7:0] shadow [V];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  string tag = "R10";

  bit         q_we[$];
  int         q_addr[$];
  logic [7:0] q_data[$];

  always #4 clk = ~clk;

  blit_engine #(.VRAM_BYTES(V)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .rop_err(rop_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: synchronous single port, one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) vram[int'(mem_addr)] <= mem_wdata;
      else        mem_rdata <= vram[int'(mem_addr)];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: every memory access is compared with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      if (q_we.size() == 0) begin
        check(0, tag, "unexpected access addr", longint'(mem_addr), -1);
      end else begin
        bit ew; int ea; logic [7:0] ed;
        ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front();
        check(mem_we == ew, tag, "access kind", longint'(mem_we), longint'(ew));
        check(int'(mem_addr) == ea, tag, "address", longint'(mem_addr), longint'(ea));
        if (ew) check(mem_wdata == ed, tag, "write data", longint'(mem_wdata), longint'(ed));
      end
    end
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic bit known(input logic [7:0] c);
    return c == 8'h00 || c == 8'h0B || c == 8'h0D || c == 8'h0E || c == 8'h59;
  endfunction

  // driver: computes the expected access stream from the requirements
  task automatic blit(input string req, input bit load_bases,
                      input logic [31:0] sb, input logic [31:0] db,
                      input int sp, input int dp, input int w, input int h,
                      input logic [7:0] mode, input logic [7:0] rop,
                      input bit mid_start);
    int n, cnt;
    bit expand;
    tag = req;
    if (load_bases) begin wr(0, sb); wr(1, db); end
    wr(2, 32'(sp)); wr(3, 32'(dp)); wr(4, 32'(w)); wr(5, 32'(h));
    wr(6, 32'(mode)); wr(7, 32'(rop));
    expand = mode[6] && mode[7];
    n = (w + 1) * (h + 1);
    for (int r = 0; r <= h; r++) begin
      for (int c = 0; c <= w; c++) begin
        logic [31:0] s, d, off;
        int sa, da;
        logic [7:0] sv, dv, res;
        off = 32'(r * sp + c);
        s  = sb + off;
        d  = db + 32'(r * dp + c);
        sa = expand ? int'(sb % 32'(V)) : int'(s % 32'(V));
        da = int'(d % 32'(V));
        q_we.push_back(0); q_addr.push_back(sa); q_data.push_back(8'h00);
        q_we.push_back(0); q_addr.push_back(da); q_data.push_back(8'h00);
        sv = expand ? {8{shadow[sa][off % 8]}} : shadow[sa];
        dv = shadow[da];
        case (rop)
          8'h00:   res = 8'h00;
          8'h0B:   res = ~dv;
          8'h0D:   res = sv;
          8'h0E:   res = 8'hFF;
          8'h59:   res = sv ^ dv;
          default: res = dv;
        endcase
        if (known(rop)) begin
          q_we.push_back(1); q_addr.push_back(da); q_data.push_back(res);
          shadow[da] = res;
        end
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (mid_start && cnt == 4) start = 1'b1;
      if (mid_start && cnt == 6) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == 3 * n, mid_start ? "R9" : "R8", "busy cycles",
          longint'(cnt), longint'(3 * n));
    check(q_we.size() == 0, req, "accesses left over", longint'(q_we.size()), 0);
    q_we.delete(); q_addr.delete(); q_data.delete();
    check(rop_err == !known(rop), "R2", "rop_err", longint'(rop_err),
          longint'(!known(rop)));
    begin
      int bad = 0;
      for (int i = 0; i < V; i++) if (vram[i] !== shadow[i]) bad++;
      check(bad == 0, req, "memory bytes differing", longint'(bad), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < V; i++) begin
      vram[i]   = 8'((i * 37 + 11) ^ (i >> 3));
      shadow[i] = vram[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(busy == 0,    "R10", "busy",    longint'(busy), 0);
    check(rop_err == 0, "R10", "rop_err", longint'(rop_err), 0);
    check(mem_en == 0,  "R10", "mem_en",  longint'(mem_en), 0);
    // R10: bases left at reset value -> one byte at address 0
    blit("R10", 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h0B, 0);
    // R1 R6 R11: copy with distinct pitches
    blit("R6", 1, 32'd100, 32'd1500, 20, 33, 4, 3, 8'h00, 8'h0D, 0);
    blit("R1", 1, 32'd200, 32'd1600, 10, 10, 5, 1, 8'h00, 8'h00, 0);
    blit("R1", 1, 32'd210, 32'd1700, 10, 12, 3, 2, 8'h00, 8'h0E, 0);
    blit("R1", 1, 32'd300, 32'd1800, 16, 16, 7, 2, 8'h00, 8'h59, 0);
    blit("R1", 1, 32'd300, 32'd1900, 16, 16, 2, 3, 8'h00, 8'h0B, 0);
    // R2: unsupported code, then cleared by a supported one
    blit("R2", 1, 32'd400, 32'd2000, 8, 8, 3, 1, 8'h00, 8'h33, 0);
    blit("R2", 1, 32'd400, 32'd2000, 8, 8, 1, 0, 8'h00, 8'h0D, 0);
    // R3: colour expand, bit index restarts per row
    vram[500] = 8'b1010_0110; shadow[500] = 8'b1010_0110;
    blit("R3", 1, 32'd500, 32'd2100, 16, 20, 11, 2, 8'hC0, 8'h0D, 0);
    blit("R3", 1, 32'd500, 32'd2200, 3, 20, 9, 2, 8'hC0, 8'h59, 0);
    // R4: pattern enable alone behaves as a normal copy
    blit("R4", 1, 32'd600, 32'd2300, 12, 12, 5, 1, 8'h40, 8'h0D, 0);
    // R5: bases beyond the size, rectangle crossing the top of memory
    blit("R5", 1, 32'(2995 + 5 * V), 32'(2990 + 2 * V), 40, 7, 9, 2, 8'h00, 8'h0D, 0);
    blit("R5", 1, 32'd2996, 32'd2994, 1, 1, 7, 0, 8'h00, 8'h59, 0);
    // R9: start pulses while busy
    blit("R9", 1, 32'd700, 32'd2400, 8, 8, 3, 2, 8'h00, 8'h0D, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule